// File: doc/BRIEF.md
# Refresh Counter Register

This block holds the processor's refresh register. It counts opcode fetches and provides a 7-bit refresh address for dynamic memory. Software can also load it through the accumulator. Each prefix byte is a fetch of its own, so an instruction with one prefix advances the count by two.

A four-byte sequence with an index prefix and a bit-operation prefix advances the count by two in total. A small sequence tracker decides which of those four fetches are counted. A separate repeat strobe stands for one more iteration of a repeating block instruction and adds two per iteration. Only the low seven bits count. The top bit keeps the value last loaded.

The sequence tracker has four states:
- `SEQ_IDLE`: no doubly-prefixed sequence is in progress.
- `SEQ_PFX2`: the first prefix has been counted.
- `SEQ_DISP`: both prefixes have been counted and the displacement byte is next.
- `SEQ_OPC`: the final opcode byte is next.

Its transitions are:
- `SEQ_IDLE -> SEQ_PFX2` on a flagged fetch.
- `SEQ_PFX2 -> SEQ_DISP` on a flagged fetch.
- `SEQ_DISP -> SEQ_OPC` on a flagged fetch.
- `SEQ_OPC -> SEQ_IDLE` on any fetch.
- Any state other than `SEQ_IDLE` returns to `SEQ_IDLE` on an unflagged fetch, which abandons the sequence.
- Every state goes to `SEQ_IDLE` on a load.

Top module: `r_refresh_ctr`

## Requirements
- R1: After reset, `r_value` is 0x00, `refresh_addr` is 0 and the tracker is in `SEQ_IDLE`.
- R2: A fetch with `dbl_idx` low adds 1 to bits 6:0, and the result is visible in the cycle after the strobe.
- R3: Two consecutive plain fetches, which is how a prefixed instruction is fetched, add 2 in total.
- R4: For four consecutive fetches with `dbl_idx` high starting in `SEQ_IDLE`, the first two add 1 each and the third and fourth add nothing. The total is 2.
- R5: Bits 6:0 wrap from 127 to 0, and counting never changes bit 7.
- R6: A load writes all eight bits from `ld_data`, including bit 7, and that bit 7 persists through later counting.
- R7: A load has priority over a fetch or repeat in the same cycle. `r_value` becomes `ld_data` exactly, and the tracker returns to `SEQ_IDLE`.
- R8: Each `blk_rpt` pulse adds 2 (mod 128). A pulse together with a counted fetch adds 3, so N iterations add 2N.
- R9: `refresh_addr` always equals `r_value[6:0]`.
- R10: A fetch with `dbl_idx` low during a sequence abandons it and counts 1. The next flagged fetch starts a new sequence and is counted.
- R11: With no fetch, repeat or load, `r_value` holds, and `dbl_idx` alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_m1 | input | 1 | Opcode fetch strobe, one cycle per fetched byte |
| dbl_idx | input | 1 | Marks the fetch as part of a doubly-prefixed indexed bit sequence |
| ld_r | input | 1 | Load strobe for the register |
| ld_data | input | 8 | Value to load (accumulator) |
| blk_rpt | input | 1 | One more iteration of a repeating block instruction |
| r_value | output | 8 | Full register value |
| refresh_addr | output | 7 | Refresh address, low seven bits |

## Verification
The bench walks the 127-to-0 wrap with bit 7 set. A design that carried into bit 7 would show 0x00 instead of 0x80.

It runs full doubly-prefixed sequences, where a design counting every byte would end four higher, not two. It also abandons a sequence partway and then starts a new one. A tracker that failed to return to idle would then drop a fetch that should count.

A load coinciding with fetch and repeat checks that the loaded value is not incremented. A load in the middle of a sequence must clear the tracker, or the next sequence would count the wrong bytes.

// File: rtl/rr_pkg.sv
package rr_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PFX2 = 2'd1,
        SEQ_DISP = 2'd2,
        SEQ_OPC  = 2'd3
    } seq_t;

    localparam int STEP_W = 2;
endpackage

// File: rtl/rr_seq_fsm.sv
module rr_seq_fsm
    import rr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fetch,
    input  logic dbl,
    input  logic clr,
    output logic counts,
    output seq_t state
);
    seq_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        counts  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (fetch) begin
                    counts = 1'b1;
                    if (dbl) state_d = SEQ_PFX2;
                end
            end
            SEQ_PFX2: begin
                if (fetch) begin
                    counts  = 1'b1;
                    state_d = dbl ? SEQ_DISP : SEQ_IDLE;
                end
            end
            SEQ_DISP: begin
                if (fetch) begin
                    counts  = !dbl;
                    state_d = dbl ? SEQ_OPC : SEQ_IDLE;
                end
            end
            SEQ_OPC: begin
                if (fetch) begin
                    counts  = !dbl;
                    state_d = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
        if (clr) state_d = SEQ_IDLE;
    end

    assign state = state_q;
endmodule

// File: rtl/rr_counter.sv
module rr_counter
    import rr_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step,
    input  logic              load,
    input  logic [CNT_W:0]    load_val,
    output logic [CNT_W:0]    value
);
    logic              hi_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            hi_q  <= load_val[CNT_W];
            cnt_q <= load_val[CNT_W-1:0];
        end else begin
            cnt_q <= cnt_q + CNT_W'(step);
        end
    end

    assign value = {hi_q, cnt_q};
endmodule

// File: rtl/r_refresh_ctr.sv
module r_refresh_ctr
    import rr_pkg::*;
#(
    parameter int CNT_W = 7,
    localparam int R_W  = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_m1,
    input  logic             dbl_idx,
    input  logic             ld_r,
    input  logic [R_W-1:0]   ld_data,
    input  logic             blk_rpt,
    output logic [R_W-1:0]   r_value,
    output logic [CNT_W-1:0] refresh_addr
);
    logic              fetch_counts;
    seq_t              seq_q;
    logic [STEP_W-1:0] step;

    rr_seq_fsm u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fetch  (fetch_m1),
        .dbl    (dbl_idx),
        .clr    (ld_r),
        .counts (fetch_counts),
        .state  (seq_q)
    );

    always_comb begin
        step = {blk_rpt, fetch_counts};
    end

    rr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (ld_r),
        .load_val (ld_data),
        .value    (r_value)
    );

    assign refresh_addr = r_value[CNT_W-1:0];
endmodule

// File: rtl/r_refresh_chk.sv
module r_refresh_chk
    import rr_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_m1,
    input logic             dbl_idx,
    input logic             ld_r,
    input logic [CNT_W:0]   ld_data,
    input logic             blk_rpt,
    input logic [CNT_W:0]   r_value,
    input seq_t             seq_q
);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_m1 && !blk_rpt && !ld_r) |=> $stable(r_value));

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_r |=> (r_value == $past(ld_data) && seq_q == SEQ_IDLE));

    p_top_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_r |=> r_value[CNT_W] == $past(r_value[CNT_W]));

    p_plain_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_m1 && !dbl_idx && !blk_rpt && !ld_r)
        |=> r_value[CNT_W-1:0] == CNT_W'($past(r_value[CNT_W-1:0]) + 1'b1));

    p_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_rpt && !fetch_m1 && !ld_r)
        |=> r_value[CNT_W-1:0] == CNT_W'($past(r_value[CNT_W-1:0]) + 2'd2));

    p_tail_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q == SEQ_DISP || seq_q == SEQ_OPC) && fetch_m1 && dbl_idx
         && !blk_rpt && !ld_r) |=> $stable(r_value));
endmodule

bind r_refresh_ctr r_refresh_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_m1 (fetch_m1),
    .dbl_idx  (dbl_idx),
    .ld_r     (ld_r),
    .ld_data  (ld_data),
    .blk_rpt  (blk_rpt),
    .r_value  (r_value),
    .seq_q    (seq_q)
);

// File: tb/sim_r_refresh_ctr.sv
`timescale 1ns/1ps
module sim_r_refresh_ctr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_m1 = 1'b0;
    logic       dbl_idx = 1'b0;
    logic       ld_r = 1'b0;
    logic [7:0] ld_data = 8'h00;
    logic       blk_rpt = 1'b0;
    logic [7:0] r_value;
    logic [6:0] refresh_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    r_refresh_ctr u0 (
        .clk(clk), .rst_n(rst_n), .fetch_m1(fetch_m1), .dbl_idx(dbl_idx),
        .ld_r(ld_r), .ld_data(ld_data), .blk_rpt(blk_rpt),
        .r_value(r_value), .refresh_addr(refresh_addr)
    );

    task automatic check(input string req, input logic [7:0] exp);
        n_cmp++;
        if (r_value !== exp) begin
            n_bad++;
            $display("FAIL %s: r_value actual %h expected %h", req, r_value, exp);
        end
        n_cmp++;
        if (refresh_addr !== exp[6:0]) begin
            n_bad++;
            $display("FAIL R9 (%s): refresh_addr actual %h expected %h",
                     req, refresh_addr, exp[6:0]);
        end
    endtask

    task automatic cyc(input logic f, input logic d, input logic r,
                       input logic l, input logic [7:0] v);
        @(negedge clk);
        fetch_m1 = f; dbl_idx = d; blk_rpt = r; ld_r = l; ld_data = v;
        @(posedge clk);
        #1;
        fetch_m1 = 1'b0; dbl_idx = 1'b0; blk_rpt = 1'b0; ld_r = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_plain;
        cyc(1, 0, 0, 0, 0); check("R2", 8'h01);
        cyc(1, 0, 0, 0, 0); check("R2", 8'h02);
        cyc(1, 0, 0, 0, 0); check("R2", 8'h03);
    endtask

    task automatic t_prefixed;
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0); check("R3", 8'h05);
    endtask

    task automatic t_double;
        cyc(1, 1, 0, 0, 0); check("R4", 8'h06);
        cyc(1, 1, 0, 0, 0); check("R4", 8'h07);
        cyc(1, 1, 0, 0, 0); check("R4", 8'h07);
        cyc(1, 1, 0, 0, 0); check("R4", 8'h07);
        cyc(1, 0, 0, 0, 0); check("R4", 8'h08);
    endtask

    task automatic t_abort;
        cyc(1, 1, 0, 0, 0); check("R10", 8'h09);
        cyc(1, 1, 0, 0, 0); check("R10", 8'h0A);
        cyc(1, 0, 0, 0, 0); check("R10", 8'h0B);
        cyc(1, 1, 0, 0, 0); check("R10", 8'h0C);
        cyc(1, 1, 0, 0, 0); check("R10", 8'h0D);
        cyc(1, 1, 0, 0, 0); check("R10", 8'h0D);
        cyc(1, 1, 0, 0, 0); check("R10", 8'h0D);
    endtask

    task automatic t_repeat;
        cyc(0, 0, 1, 0, 0); check("R8", 8'h0F);
        cyc(1, 0, 1, 0, 0); check("R8", 8'h12);
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0);
        check("R8", 8'h1C);
    endtask

    task automatic t_load_wrap;
        cyc(0, 0, 0, 1, 8'hFE); check("R6", 8'hFE);
        cyc(1, 0, 0, 0, 0);     check("R5", 8'hFF);
        cyc(1, 0, 0, 0, 0);     check("R5", 8'h80);
        cyc(0, 0, 1, 0, 0);     check("R6", 8'h82);
        cyc(0, 0, 0, 1, 8'h7F); check("R6", 8'h7F);
        cyc(0, 0, 1, 0, 0);     check("R5", 8'h01);
    endtask

    task automatic t_load_priority;
        cyc(1, 0, 1, 1, 8'h45); check("R7", 8'h45);
        cyc(1, 1, 0, 0, 0);     check("R7", 8'h46);
        cyc(1, 1, 0, 1, 8'h10); check("R7", 8'h10);
        cyc(1, 1, 0, 0, 0);     check("R7", 8'h11);
        cyc(1, 1, 0, 0, 0);     check("R7", 8'h12);
        cyc(1, 1, 0, 0, 0);     check("R7", 8'h12);
        cyc(1, 1, 0, 0, 0);     check("R7", 8'h12);
    endtask

    task automatic t_idle_hold;
        cyc(0, 0, 0, 0, 8'hAA); check("R11", 8'h12);
        cyc(0, 1, 0, 0, 8'h55); check("R11", 8'h12);
        cyc(0, 0, 0, 0, 0);     check("R11", 8'h12);
    endtask

    initial begin
        t_reset;
        t_plain;
        t_prefixed;
        t_double;
        t_abort;
        t_repeat;
        t_load_wrap;
        t_load_priority;
        t_idle_hold;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule